// File: doc/BRIEF.md
# Tightly Coupled Memory Router

This block sits between a 32-bit CPU load/store port and the system bus. It holds two small on-chip byte arrays: an instruction-side memory (I-mem) and a data-side memory (D-mem). Each access is a byte, halfword or word. The router decides, on the cycle the request is accepted, which target serves the access: I-mem, D-mem or the external bus. It then performs the little-endian read or write in the chosen array, or runs a request/acknowledge transaction on the bus.

Each memory has four settings:
- a programmable base address;
- a power-of-two size, fixed by a parameter;
- an enable bit;
- a load-mode bit.

In load mode the memory stops claiming reads, which go to the bus, but it keeps accepting writes. This allows the array to be filled while reads still come from the backing store. The enable and load-mode bits live in a control word. That word and the two base registers are written through a small configuration port.

Top module: `tcm_router`

## Requirements
- R1: An access falls inside a memory's window when base ≤ address < base + size (lower bound inclusive, upper bound exclusive); addresses below base or at base + size are not claimed by that memory.
- R2: The array index is the aligned address ANDed with (size − 1), so the data stored at an index is seen at every window position that maps to that index, including after the base is moved.
- R3: When both windows contain the address and both memories would claim the access, I-mem serves it and D-mem is untouched.
- R4: A memory whose enable bit is 0 claims neither reads nor writes; such accesses go to the bus and leave the array unchanged.
- R5: A memory with its load-mode bit set does not claim reads, which go to the bus (or to D-mem if I-mem is in load mode and D-mem claims), but it still claims and stores writes.
- R6: `cfg_sel` selects the target of a configuration write: 0 is the control word, 1 is the I-mem base, 2 is the D-mem base. In the control word, bit 16 is the D-mem enable, bit 17 the D-mem load mode, bit 18 the I-mem enable and bit 19 the I-mem load mode.
- R7: `cpu_size` encodes 0 = byte, 1 = halfword, 2 = word. Data is little-endian and sits in the low bits of `cpu_wdata`/`cpu_rdata`, and read data is zero-extended. The address is aligned down (bit 0 ignored for halfwords, bits 1:0 for words).
- R8: A request accepted while `cpu_ready` is 1 that hits a memory raises `cpu_done` for exactly the next cycle and raises no bus request.
- R9: A bus access holds `bus_req`, the aligned `bus_addr`, `bus_we`, `bus_size` and `bus_wdata` stable until `bus_ack`. `cpu_done` follows in the next cycle, with the bus read data masked to the access size, and `cpu_ready` is 0 in between.
- R10: After reset both memories are enabled with load mode clear, the I-mem base is 0, the D-mem base is `DMEM_RESET_BASE`, `cpu_ready` is 1 and `cpu_done` and `bus_req` are 0.
- R11: A configuration write governs a request issued in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 control, 1 I-mem base, 2 D-mem base |
| cfg_wdata | input | 32 | Configuration write data |
| cpu_req | input | 1 | Access request, accepted when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data, low-aligned |
| cpu_ready | output | 1 | Router can accept a request |
| cpu_done | output | 1 | Access completed this cycle |
| cpu_rdata | output | 32 | Read data, zero-extended, valid with `cpu_done` |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | Bus write |
| bus_size | output | 2 | Bus access size |
| bus_addr | output | 32 | Aligned bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |

## Verification
The bench probes the window edges one word below the base, at the base, at the last word and at base + size. A design with an inclusive upper bound or an exclusive lower bound would serve a bus address from the array, or the reverse. It makes the two windows overlap and then disables I-mem to read back what D-mem holds. A router with the wrong priority would show I-mem data in D-mem.

Both enable and load mode are tested with a write followed by a read-back. A design that dropped disabled writes into the array, or sent load-mode writes to the bus, would return the wrong word. The bench also moves the D-mem base and re-reads the same index, which exposes an index built from address − base instead of the masked address. It issues requests in the cycle right after each configuration write to catch delayed control.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_t;

  typedef enum logic [1:0] {
    CFG_CTRL  = 2'd0,
    CFG_IBASE = 2'd1,
    CFG_DBASE = 2'd2
  } cfg_sel_t;

  typedef enum logic [1:0] {
    RT_IMEM = 2'd0,
    RT_DMEM = 2'd1,
    RT_BUS  = 2'd2
  } route_t;

  localparam int CTL_DEN_BIT = 16;
  localparam int CTL_DLD_BIT = 17;
  localparam int CTL_IEN_BIT = 18;
  localparam int CTL_ILD_BIT = 19;

  typedef struct packed {
    logic        en;
    logic        ld;
    logic [31:0] base;
  } mem_cfg_t;

  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [32:0] span);
    logic [32:0] lim;
    lim = {1'b0, base} + span;
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction

  function automatic logic [31:0] align_addr(input logic [31:0] a,
                                             input acc_size_t sz);
    case (sz)
      SZ_BYTE: return a;
      SZ_HALF: return {a[31:1], 1'b0};
      default: return {a[31:2], 2'b00};
    endcase
  endfunction

  function automatic logic [2:0] byte_count(input acc_size_t sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input acc_size_t sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/tcm_cfg_regs.sv
module tcm_cfg_regs
  import tcm_pkg::*;
#(
  parameter logic [31:0] DMEM_RESET_BASE = 32'h0080_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output mem_cfg_t    imem_cfg,
  output mem_cfg_t    dmem_cfg
);

  logic ctrl_wr, ibase_wr, dbase_wr;
  assign ctrl_wr  = cfg_we && (cfg_sel_t'(cfg_sel) == CFG_CTRL);
  assign ibase_wr = cfg_we && (cfg_sel_t'(cfg_sel) == CFG_IBASE);
  assign dbase_wr = cfg_we && (cfg_sel_t'(cfg_sel) == CFG_DBASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imem_cfg <= '{en: 1'b1, ld: 1'b0, base: 32'h0};
      dmem_cfg <= '{en: 1'b1, ld: 1'b0, base: DMEM_RESET_BASE};
    end else begin
      if (ctrl_wr) begin
        imem_cfg.en <= cfg_wdata[CTL_IEN_BIT];
        imem_cfg.ld <= cfg_wdata[CTL_ILD_BIT];
        dmem_cfg.en <= cfg_wdata[CTL_DEN_BIT];
        dmem_cfg.ld <= cfg_wdata[CTL_DLD_BIT];
      end
      if (ibase_wr) imem_cfg.base <= cfg_wdata;
      if (dbase_wr) dmem_cfg.base <= cfg_wdata;
    end
  end

  AST_CTRL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (imem_cfg.en == $past(cfg_wdata[CTL_IEN_BIT])) &&
                (imem_cfg.ld == $past(cfg_wdata[CTL_ILD_BIT])) &&
                (dmem_cfg.en == $past(cfg_wdata[CTL_DEN_BIT])) &&
                (dmem_cfg.ld == $past(cfg_wdata[CTL_DLD_BIT]))); // R6

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dbase_wr |=> dmem_cfg.base == $past(cfg_wdata)); // R11

endmodule

// File: rtl/tcm_route.sv
module tcm_route
  import tcm_pkg::*;
#(
  parameter int IMEM_BYTES = 1024,
  parameter int DMEM_BYTES = 512
) (
  input  logic [31:0] addr,
  input  logic        we,
  input  mem_cfg_t    imem_cfg,
  input  mem_cfg_t    dmem_cfg,
  output logic        imem_claim,
  output logic        dmem_claim,
  output route_t      route
);

  localparam logic [32:0] ISPAN = 33'(IMEM_BYTES);
  localparam logic [32:0] DSPAN = 33'(DMEM_BYTES);

  logic imem_win, dmem_win;
  assign imem_win = in_window(addr, imem_cfg.base, ISPAN);
  assign dmem_win = in_window(addr, dmem_cfg.base, DSPAN);

  // reads skip a memory in load mode; writes do not
  assign imem_claim = imem_cfg.en && imem_win && (we || !imem_cfg.ld);
  assign dmem_claim = dmem_cfg.en && dmem_win && (we || !dmem_cfg.ld);

  always_comb begin
    if (imem_claim)      route = RT_IMEM;
    else if (dmem_claim) route = RT_DMEM;
    else                 route = RT_BUS;
  end

endmodule

// File: rtl/tcm_bank.sv
module tcm_bank #(
  parameter int BYTES = 1024,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [2:0]       nbytes,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < 4; k++) begin
        if (3'(k) < nbytes) mem[idx + IDX_W'(k)] <= wdata[8*k +: 8];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) rdata[8*k +: 8] = mem[idx + IDX_W'(k)];
  end

endmodule

// File: rtl/tcm_router.sv
module tcm_router
  import tcm_pkg::*;
#(
  parameter int          IMEM_BYTES      = 1024,
  parameter int          DMEM_BYTES      = 512,
  parameter logic [31:0] DMEM_RESET_BASE = 32'h0080_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic        cpu_done,
  output logic [31:0] cpu_rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [1:0]  bus_size,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);

  localparam int NBANK = 2;

  mem_cfg_t  imem_cfg, dmem_cfg;
  route_t    route;
  logic      imem_claim, dmem_claim;
  acc_size_t req_sz;
  logic [31:0] req_aligned;
  logic [2:0]  req_nbytes;

  logic        busy_q, done_q;
  logic [31:0] rdata_q;
  logic        pend_we;
  acc_size_t   pend_sz;
  logic [31:0] pend_addr, pend_wdata;

  // named events used by the assertions
  logic issue, mem_hit, bus_miss, bus_done;

  logic [31:0] bank_rdata [NBANK];

  tcm_cfg_regs #(.DMEM_RESET_BASE(DMEM_RESET_BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .imem_cfg(imem_cfg), .dmem_cfg(dmem_cfg)
  );

  assign req_sz      = acc_size_t'(cpu_size);
  assign req_aligned = align_addr(cpu_addr, req_sz);
  assign req_nbytes  = byte_count(req_sz);

  tcm_route #(.IMEM_BYTES(IMEM_BYTES), .DMEM_BYTES(DMEM_BYTES)) u_route (
    .addr(req_aligned), .we(cpu_we), .imem_cfg(imem_cfg), .dmem_cfg(dmem_cfg),
    .imem_claim(imem_claim), .dmem_claim(dmem_claim), .route(route)
  );

  assign issue    = cpu_req && !busy_q;
  assign mem_hit  = issue && (route != RT_BUS);
  assign bus_miss = issue && (route == RT_BUS);
  assign bus_done = busy_q && bus_ack;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam int     BYTES = (g == 0) ? IMEM_BYTES : DMEM_BYTES;
    localparam route_t MINE  = (g == 0) ? RT_IMEM : RT_DMEM;
    logic wr_en;
    assign wr_en = issue && cpu_we && (route == MINE);
    tcm_bank #(.BYTES(BYTES)) u_bank (
      .clk(clk), .wr_en(wr_en), .idx(req_aligned[$clog2(BYTES)-1:0]),
      .nbytes(req_nbytes), .wdata(cpu_wdata), .rdata(bank_rdata[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      rdata_q    <= '0;
      pend_we    <= 1'b0;
      pend_sz    <= SZ_WORD;
      pend_addr  <= '0;
      pend_wdata <= '0;
    end else begin
      done_q <= 1'b0;
      if (mem_hit) begin
        done_q  <= 1'b1;
        rdata_q <= cpu_we ? 32'h0 :
                   (bank_rdata[(route == RT_IMEM) ? 0 : 1] & size_mask(req_sz));
      end else if (bus_miss) begin
        busy_q     <= 1'b1;
        pend_we    <= cpu_we;
        pend_sz    <= req_sz;
        pend_addr  <= req_aligned;
        pend_wdata <= cpu_wdata;
      end else if (bus_done) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= pend_we ? 32'h0 : (bus_rdata & size_mask(pend_sz));
      end
    end
  end

  assign cpu_ready = !busy_q;
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign bus_req   = busy_q;
  assign bus_we    = pend_we;
  assign bus_size  = pend_sz;
  assign bus_addr  = pend_addr;
  assign bus_wdata = pend_wdata;

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |=> cpu_done && !bus_req); // R8

  AST_MISS_GOES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_miss |=> bus_req && !cpu_done); // R4

  AST_BUS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && !cpu_done && $stable(bus_addr) &&
                            $stable(bus_wdata) && $stable(bus_we)); // R9

  AST_BUS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> cpu_done && !bus_req && cpu_ready); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_ready); // R8

endmodule

// File: tb/tcm_router_tb.sv
module tcm_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd2;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_we;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #5 clk = ~clk;

  tcm_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // bus model pattern: aligned address XOR constant, masked to the size
  function automatic logic [31:0] bus_pat(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] al, m;
    al = (sz == 2'd0) ? a : (sz == 2'd1) ? {a[31:1], 1'b0} : {a[31:2], 2'b00};
    m  = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return (32'h5A00_0000 ^ al) & m;
  endfunction

  // ---------------- bus slave model ----------------
  logic        bus_seen = 1'b0;
  logic [31:0] last_bw_addr = '0, last_bw_data = '0;
  int          wait_cnt = 0;

  always @(negedge clk) begin
    if (bus_req === 1'b1) begin
      if (wait_cnt == 2) begin
        bus_ack   = 1'b1;
        bus_rdata = 32'h5A00_0000 ^ bus_addr;
        bus_seen  = 1'b1;
        if (bus_we) begin
          last_bw_addr = bus_addr;
          last_bw_data = bus_wdata;
        end
        wait_cnt = 0;
      end else begin
        bus_ack = 1'b0;
        wait_cnt++;
      end
    end else begin
      bus_ack  = 1'b0;
      wait_cnt = 0;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic        chk_data;
    logic [31:0] data;
    logic        exp_bus;
  } sb_t;
  sb_t   sb_q[$];
  string tag_q[$];

  always @(negedge clk) begin
    if (rst_n && cpu_done === 1'b1) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8 unexpected done", 32'h1, 32'h0);
      end else begin
        sb_t   it;
        string tg;
        it = sb_q.pop_front();
        tg = tag_q.pop_front();
        if (it.chk_data) chk(cpu_rdata === it.data, {tg, " data"}, cpu_rdata, it.data);
        chk(bus_seen === it.exp_bus, {tg, " route"}, {31'd0, bus_seen}, {31'd0, it.exp_bus});
      end
    end
  end

  // ---------------- driver ----------------
  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input logic cd, input logic [31:0] ed,
                        input logic eb, input string tag);
    sb_t it;
    while (cpu_ready !== 1'b1) @(negedge clk);
    bus_seen = 1'b0;
    it = '{chk_data: cd, data: ed, exp_bus: eb};
    sb_q.push_back(it);
    tag_q.push_back(tag);
    cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    while (cpu_done !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] ed,
                    input logic eb, input string tag);
    access(1'b0, sz, a, 32'h0, 1'b1, ed, eb, tag);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd,
                    input logic eb, input string tag);
    access(1'b1, sz, a, wd, 1'b0, 32'h0, eb, tag);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] CTL_BOTH  = 32'h0005_0000; // bits 16 and 18
  localparam logic [31:0] CTL_DONLY = 32'h0001_0000;
  localparam logic [31:0] CTL_ILOAD = 32'h000D_0000; // + bit 19
  localparam logic [31:0] CTL_DLOAD = 32'h0007_0000; // + bit 17

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(cpu_ready === 1'b1, "R10 ready", {31'd0, cpu_ready}, 32'h1);
    chk(cpu_done === 1'b0, "R10 done", {31'd0, cpu_done}, 32'h0);
    chk(bus_req === 1'b0, "R10 bus_req", {31'd0, bus_req}, 32'h0);

    // R8 / R7: I-mem word, byte, half, alignment
    wr(2'd2, 32'h0, 32'h1122_3344, 1'b0, "R8 imem write");
    rd(2'd2, 32'h0, 32'h1122_3344, 1'b0, "R8 imem read");
    rd(2'd0, 32'h1, 32'h0000_0033, 1'b0, "R7 byte lane1");
    rd(2'd1, 32'h2, 32'h0000_1122, 1'b0, "R7 upper half");
    rd(2'd1, 32'h3, 32'h0000_1122, 1'b0, "R7 half align");
    rd(2'd2, 32'h2, 32'h1122_3344, 1'b0, "R7 word align");
    wr(2'd2, 32'h4, 32'h0, 1'b0, "R7 clear");
    wr(2'd0, 32'h5, 32'hFFFF_FFAA, 1'b0, "R7 byte write");
    rd(2'd2, 32'h4, 32'h0000_AA00, 1'b0, "R7 byte merge");
    wr(2'd1, 32'h6, 32'h0000_BEEF, 1'b0, "R7 half write");
    rd(2'd2, 32'h4, 32'hBEEF_AA00, 1'b0, "R7 half merge");

    // R1 I-mem upper edge
    wr(2'd2, 32'h3FC, 32'hCAFE_F00D, 1'b0, "R1 imem last word");
    rd(2'd2, 32'h3FC, 32'hCAFE_F00D, 1'b0, "R1 imem last word");
    rd(2'd2, 32'h400, bus_pat(32'h400, 2'd2), 1'b1, "R1 imem end excl");

    // R10 D-mem reset base
    wr(2'd2, 32'h0080_0000, 32'h0D0D_0D0D, 1'b0, "R10 dmem base");
    rd(2'd2, 32'h0080_0000, 32'h0D0D_0D0D, 1'b0, "R10 dmem base");

    // R1 D-mem window with unaligned base
    cfg(2'd2, 32'h0080_0100);
    rd(2'd2, 32'h0080_00FC, bus_pat(32'h0080_00FC, 2'd2), 1'b1, "R1 below base");
    wr(2'd2, 32'h0080_0100, 32'h0101_0101, 1'b0, "R1 at base");
    rd(2'd2, 32'h0080_0100, 32'h0101_0101, 1'b0, "R1 at base");
    wr(2'd2, 32'h0080_02FC, 32'h0202_0202, 1'b0, "R1 last word");
    rd(2'd2, 32'h0080_0300, bus_pat(32'h0080_0300, 2'd2), 1'b1, "R1 end excl");
    wr(2'd2, 32'h0080_0200, 32'h3344_5566, 1'b0, "R2 index 0");

    // R2 / R11 mirroring after moving the base, request right after write
    cfg(2'd2, 32'h0090_0000);
    rd(2'd2, 32'h0090_0000, 32'h3344_5566, 1'b0, "R2 R11 mirror idx0");
    rd(2'd2, 32'h0090_0100, 32'h0101_0101, 1'b0, "R2 mirror idx100");

    // R3 overlap priority
    cfg(2'd2, 32'h0);
    wr(2'd2, 32'h0, 32'h7777_7777, 1'b0, "R3 overlap write");
    cfg(2'd0, CTL_DONLY);
    rd(2'd2, 32'h0, 32'h3344_5566, 1'b0, "R3 R6 dmem untouched");
    cfg(2'd0, CTL_BOTH);
    rd(2'd2, 32'h0, 32'h7777_7777, 1'b0, "R3 imem wins");

    // R4 disabled memories
    cfg(2'd2, 32'h0090_0000);
    wr(2'd2, 32'h10, 32'h1010_1010, 1'b0, "R4 prefill");
    cfg(2'd0, 32'h0);
    wr(2'd2, 32'h10, 32'hDEAD_BEEF, 1'b1, "R4 disabled write");
    chk(last_bw_addr === 32'h10, "R4 bus waddr", last_bw_addr, 32'h10);
    chk(last_bw_data === 32'hDEAD_BEEF, "R4 bus wdata", last_bw_data, 32'hDEAD_BEEF);
    rd(2'd2, 32'h10, bus_pat(32'h10, 2'd2), 1'b1, "R4 disabled read");
    rd(2'd0, 32'h0090_0001, bus_pat(32'h0090_0001, 2'd0), 1'b1, "R9 R4 byte mask");
    cfg(2'd0, CTL_BOTH);
    rd(2'd2, 32'h10, 32'h1010_1010, 1'b0, "R4 array unchanged");

    // R5 load mode
    cfg(2'd0, CTL_ILOAD);
    rd(2'd2, 32'h0, bus_pat(32'h0, 2'd2), 1'b1, "R5 imem load read");
    wr(2'd2, 32'h0, 32'h9988_7766, 1'b0, "R5 imem load write");
    cfg(2'd0, CTL_BOTH);
    rd(2'd2, 32'h0, 32'h9988_7766, 1'b0, "R5 imem stored");
    cfg(2'd0, CTL_DLOAD);
    rd(2'd2, 32'h0090_0000, bus_pat(32'h0090_0000, 2'd2), 1'b1, "R5 R6 dmem load read");
    wr(2'd2, 32'h0090_0004, 32'h1234_5678, 1'b0, "R5 dmem load write");
    cfg(2'd0, CTL_BOTH);
    rd(2'd2, 32'h0090_0004, 32'h1234_5678, 1'b0, "R5 dmem stored");

    // R9 bus halfword masking
    rd(2'd1, 32'h0000_2003, bus_pat(32'h0000_2003, 2'd1), 1'b1, "R9 half mask");
    chk(last_bw_addr === 32'h10, "R9 no stray bus write", last_bw_addr, 32'h10);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R8 all done", 32'(sb_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule